// File: doc/BRIEF.md
# Host Command Mailbox Responder

This block sits on the device side of a host register window. The host fills a subsystem-select word and a small bank of parameter words, then writes a command opcode into a mailbox word. The block clears the completion byte of that same word, waits a fixed number of cycles, and then decodes the opcode against the selected subsystem. It carries out the operation: single read, single write, configure, read back configuration, start or stop. The result goes into the parameter words. A completion code is then posted in the upper byte of the mailbox and a command-done flag is raised.

The converter, digital-port, memory and counter back ends are stand-ins made of small register files. Analog out, digital out, memory and counter/timer each own a writable file. The analog-in path reads back the analog-out file scaled by a gain shift. The digital-in path reads back the digital-out file. A host driver writes the command and then polls the mailbox until the completion byte turns nonzero. The fixed latency is bounded at elaboration so that it always finishes inside the host's poll budget.

Top module: `hmr_mailbox_responder`

## Requirements
- R1: After reset every mapped host word (mailbox, subsystem select, all parameter words) reads 0 and `cmd_done` is low.
- R2: A host write to the mailbox stores the low byte as the opcode and forces the status byte to 0x00, whatever upper byte was written. It also clears `cmd_done` at the same clock edge.
- R3: The completion code and `cmd_done` appear exactly LATENCY clock edges after the mailbox write edge. Until then the status byte stays 0x00. LATENCY must be at least 1 and below the host poll limit MAX_POLL (default 100). `cmd_done` then stays high until the next mailbox write.
- R4: The status byte only ever holds 0x00 (pending), 0x55 (success), 0xAA (error) or 0xFF (unsupported).
- R5: Opcode 6 (single write) stores parameter 2 into entry `parameter 0` of the selected file. This applies to subsystems 1 (analog out), 3 (digital out), 4 (memory) and 5 (counter/timer). The command completes with 0x55 and the parameter words are unchanged.
- R6: Opcode 5 (single read) returns a value in parameter 2 with 0x55. Subsystems 1, 3, 4 and 5 return their stored entry. Subsystem 2 (digital in) returns the digital-out entry. Subsystem 0 (analog in) returns the analog-out entry shifted right by the gain in parameter 1 (0 to GAIN_LEVELS-1).
- R7: Opcode 1 (configure) stores parameter 0 as the selected subsystem's configuration. Opcode 2 (get configuration) returns that configuration in parameter 0 and the subsystem's run flag in bit 0 of parameter 1. Both complete with 0x55.
- R8: Opcode 3 (start) sets and opcode 4 (stop) clears the run flag of the selected subsystem, completing with 0x55.
- R9: The following complete with 0xAA and change neither the parameter words nor any stored file: a subsystem select above 5 on opcodes 1 to 6, a channel of NUM_CHANNELS or more on opcodes 5 and 6, a gain of GAIN_LEVELS or more on an analog-in read, and a single write to subsystem 0 or 2.
- R10: Every opcode other than 1 to 6 completes with 0xFF and leaves the parameter words unchanged.
- R11: The host map is: address 0 is the mailbox {status[15:8], opcode[7:0]}, address 1 is the subsystem select, and address 2+i is parameter i. Other addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host write word address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | ADDR_W | Host read word address |
| host_rdata | output | 16 | Host read data (combinational) |
| cmd_done | output | 1 | Command-done flag, set with the completion code |

## Verification
The assertions assume the host does not write the mailbox, subsystem select or parameter words while a command is pending. The one exception is a fresh mailbox write, which restarts the wait. The latency and pending-status properties would still hold under other traffic, but the parameter contents would then depend on write ordering. The stimulus waits for every command to post and for the done flag to be seen held before it touches any register again. All register setup happens between commands.

// File: rtl/hmr_pkg.sv
package hmr_pkg;

   localparam int WORD_W     = 16;
   localparam int NUM_SUBSYS = 6;
   localparam int SS_W       = 3;
   localparam int PARAM_BASE = 2;

   // completion codes carried in the mailbox upper byte
   localparam logic [7:0] ST_PENDING = 8'h00;
   localparam logic [7:0] ST_OK      = 8'h55;
   localparam logic [7:0] ST_ERR     = 8'hAA;
   localparam logic [7:0] ST_UNSUP   = 8'hFF;

   // decoded opcodes
   localparam logic [7:0] OP_CONFIG = 8'd1;
   localparam logic [7:0] OP_GETCFG = 8'd2;
   localparam logic [7:0] OP_START  = 8'd3;
   localparam logic [7:0] OP_STOP   = 8'd4;
   localparam logic [7:0] OP_RDSGL  = 8'd5;
   localparam logic [7:0] OP_WRSGL  = 8'd6;

   // subsystem selector codes
   localparam int SS_AIN  = 0;
   localparam int SS_AOUT = 1;
   localparam int SS_DIN  = 2;
   localparam int SS_DOUT = 3;
   localparam int SS_MEM  = 4;
   localparam int SS_CTR  = 5;

   // subsystems that own a writable stub file
   localparam logic [NUM_SUBSYS-1:0] SS_WRITABLE = 6'b11_1010;

   typedef struct packed {
      logic [7:0] status;
      logic [7:0] opcode;
   } mbox_word_t;

endpackage

// File: rtl/hmr_host_regs.sv
module hmr_host_regs
   import hmr_pkg::*;
#(
   parameter int NUM_PARAMS = 8,
   parameter int ADDR_W     = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               host_we,
   input  logic [ADDR_W-1:0]                  host_addr,
   input  logic [WORD_W-1:0]                  host_wdata,
   input  logic [ADDR_W-1:0]                  host_raddr,
   output logic [WORD_W-1:0]                  host_rdata,
   input  logic                               post,
   input  logic [7:0]                         post_status,
   input  logic [NUM_PARAMS-1:0]              res_we,
   input  logic [NUM_PARAMS-1:0][WORD_W-1:0]  res_val,
   output logic                               mbox_kick,
   output logic [7:0]                         opcode,
   output logic [7:0]                         status,
   output logic [WORD_W-1:0]                  subsys,
   output logic [NUM_PARAMS-1:0][WORD_W-1:0]  params,
   output logic                               done
);

   localparam logic [ADDR_W-1:0] A_MBOX = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(1);

   mbox_word_t mbox_q;

   assign mbox_kick = host_we && (host_addr == A_MBOX);
   assign opcode    = mbox_q.opcode;
   assign status    = mbox_q.status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mbox_q <= '0;
         done   <= 1'b0;
      end else if (mbox_kick) begin
         mbox_q.opcode <= host_wdata[7:0];
         mbox_q.status <= ST_PENDING;
         done          <= 1'b0;
      end else if (post) begin
         mbox_q.status <= post_status;
         done          <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         subsys <= '0;
      else if (host_we && (host_addr == A_SUB))
         subsys <= host_wdata;
   end

   for (genvar gi = 0; gi < NUM_PARAMS; gi++) begin : g_param
      localparam logic [ADDR_W-1:0] A_THIS = ADDR_W'(PARAM_BASE + gi);
      logic host_hit;
      assign host_hit = host_we && (host_addr == A_THIS);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            params[gi] <= '0;
         else if (host_hit)
            params[gi] <= host_wdata;
         else if (post && res_we[gi])
            params[gi] <= res_val[gi];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_raddr == A_MBOX)
         host_rdata = mbox_q;
      else if (host_raddr == A_SUB)
         host_rdata = subsys;
      else
         for (int i = 0; i < NUM_PARAMS; i++)
            if (host_raddr == ADDR_W'(PARAM_BASE + i))
               host_rdata = params[i];
   end

endmodule

// File: rtl/hmr_sequencer.sv
module hmr_sequencer #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic fire,
   output logic busy
);

   localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (kick) begin
         busy  <= 1'b1;
         cnt_q <= CNT_W'(LATENCY - 1);
      end else if (busy) begin
         if (cnt_q == '0)
            busy <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign fire = busy && (cnt_q == '0) && !kick;

endmodule

// File: rtl/hmr_exec.sv
module hmr_exec
   import hmr_pkg::*;
#(
   parameter int NUM_PARAMS   = 8,
   parameter int NUM_CHANNELS = 8,
   parameter int GAIN_LEVELS  = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               fire,
   input  logic [7:0]                         opcode,
   input  logic [WORD_W-1:0]                  subsys,
   input  logic [NUM_PARAMS-1:0][WORD_W-1:0]  params,
   output logic [7:0]                         status_code,
   output logic [NUM_PARAMS-1:0]              res_we,
   output logic [NUM_PARAMS-1:0][WORD_W-1:0]  res_val
);

   localparam int CH_W = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1;
   localparam int GN_W = (GAIN_LEVELS > 1) ? $clog2(GAIN_LEVELS) : 1;

   logic                             ss_ok, chan_ok, gain_ok;
   logic [SS_W-1:0]                  ss_idx;
   logic [CH_W-1:0]                  chan_idx;
   logic [GN_W-1:0]                  gain_sh;
   logic [NUM_SUBSYS-1:0][WORD_W-1:0] stored;
   logic [WORD_W-1:0]                cfg_q [NUM_SUBSYS];
   logic [NUM_SUBSYS-1:0]            run_q;
   logic [WORD_W-1:0]                rd_val;
   logic                             store_en, cfg_en, run_set, run_clr;

   assign ss_ok    = subsys < WORD_W'(NUM_SUBSYS);
   assign ss_idx   = ss_ok ? subsys[SS_W-1:0] : '0;
   assign chan_ok  = params[0] < WORD_W'(NUM_CHANNELS);
   assign chan_idx = chan_ok ? params[0][CH_W-1:0] : '0;
   assign gain_ok  = params[1] < WORD_W'(GAIN_LEVELS);
   assign gain_sh  = params[1][GN_W-1:0];

   // stub files: only output-capable subsystems own storage
   for (genvar gs = 0; gs < NUM_SUBSYS; gs++) begin : g_sub
      if (SS_WRITABLE[gs]) begin : g_file
         logic [WORD_W-1:0] file_q [NUM_CHANNELS];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int c = 0; c < NUM_CHANNELS; c++)
                  file_q[c] <= '0;
            end else if (fire && store_en && (ss_idx == SS_W'(gs))) begin
               file_q[chan_idx] <= params[2];
            end
         end
         assign stored[gs] = file_q[chan_idx];
      end else begin : g_none
         assign stored[gs] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SUBSYS; s++)
            cfg_q[s] <= '0;
         run_q <= '0;
      end else if (fire) begin
         if (cfg_en)
            cfg_q[ss_idx] <= params[0];
         if (run_set)
            run_q[ss_idx] <= 1'b1;
         else if (run_clr)
            run_q[ss_idx] <= 1'b0;
      end
   end

   // read path: input subsystems loop back from their output partners
   always_comb begin
      case (ss_idx)
         SS_W'(SS_AIN): rd_val = stored[SS_AOUT] >> gain_sh;
         SS_W'(SS_DIN): rd_val = stored[SS_DOUT];
         default:       rd_val = stored[ss_idx];
      endcase
   end

   always_comb begin
      status_code = ST_UNSUP;
      res_we      = '0;
      res_val     = '0;
      store_en    = 1'b0;
      cfg_en      = 1'b0;
      run_set     = 1'b0;
      run_clr     = 1'b0;
      case (opcode)
         OP_CONFIG: begin
            status_code = ss_ok ? ST_OK : ST_ERR;
            cfg_en      = ss_ok;
         end
         OP_GETCFG: begin
            status_code = ss_ok ? ST_OK : ST_ERR;
            res_we[0]   = ss_ok;
            res_we[1]   = ss_ok;
            res_val[0]  = cfg_q[ss_idx];
            res_val[1]  = {{(WORD_W-1){1'b0}}, run_q[ss_idx]};
         end
         OP_START: begin
            status_code = ss_ok ? ST_OK : ST_ERR;
            run_set     = ss_ok;
         end
         OP_STOP: begin
            status_code = ss_ok ? ST_OK : ST_ERR;
            run_clr     = ss_ok;
         end
         OP_RDSGL: begin
            if (ss_ok && chan_ok && ((ss_idx != SS_W'(SS_AIN)) || gain_ok)) begin
               status_code = ST_OK;
               res_we[2]   = 1'b1;
               res_val[2]  = rd_val;
            end else begin
               status_code = ST_ERR;
            end
         end
         OP_WRSGL: begin
            if (ss_ok && chan_ok && SS_WRITABLE[ss_idx]) begin
               status_code = ST_OK;
               store_en    = 1'b1;
            end else begin
               status_code = ST_ERR;
            end
         end
         default: status_code = ST_UNSUP;
      endcase
   end

endmodule

// File: rtl/hmr_mailbox_responder.sv
module hmr_mailbox_responder
   import hmr_pkg::*;
#(
   parameter int NUM_PARAMS   = 8,
   parameter int NUM_CHANNELS = 8,
   parameter int GAIN_LEVELS  = 4,
   parameter int LATENCY      = 4,
   parameter int MAX_POLL     = 100,
   parameter int ADDR_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [15:0]       host_wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [15:0]       host_rdata,
   output logic              cmd_done
);

   if (NUM_PARAMS < 3) begin : g_bad_params
      $error("hmr_mailbox_responder: NUM_PARAMS must be at least 3");
   end
   if (PARAM_BASE + NUM_PARAMS > (1 << ADDR_W)) begin : g_bad_addr
      $error("hmr_mailbox_responder: ADDR_W too narrow for the parameter bank");
   end
   if (LATENCY < 1 || LATENCY >= MAX_POLL) begin : g_bad_lat
      $error("hmr_mailbox_responder: LATENCY must be in 1..MAX_POLL-1");
   end
   if (NUM_CHANNELS < 1 || GAIN_LEVELS < 1) begin : g_bad_sizes
      $error("hmr_mailbox_responder: channel and gain counts must be positive");
   end

   logic                              mbox_kick, seq_fire, seq_busy;
   logic [7:0]                        mbox_opcode, mbox_status, exec_status;
   logic [WORD_W-1:0]                 subsys_sel;
   logic [NUM_PARAMS-1:0][WORD_W-1:0] param_words, exec_val;
   logic [NUM_PARAMS-1:0]             exec_we;

   hmr_host_regs #(
      .NUM_PARAMS (NUM_PARAMS),
      .ADDR_W     (ADDR_W)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_we     (host_we),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_raddr  (host_raddr),
      .host_rdata  (host_rdata),
      .post        (seq_fire),
      .post_status (exec_status),
      .res_we      (exec_we),
      .res_val     (exec_val),
      .mbox_kick   (mbox_kick),
      .opcode      (mbox_opcode),
      .status      (mbox_status),
      .subsys      (subsys_sel),
      .params      (param_words),
      .done        (cmd_done)
   );

   hmr_sequencer #(
      .LATENCY (LATENCY)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (mbox_kick),
      .fire  (seq_fire),
      .busy  (seq_busy)
   );

   hmr_exec #(
      .NUM_PARAMS   (NUM_PARAMS),
      .NUM_CHANNELS (NUM_CHANNELS),
      .GAIN_LEVELS  (GAIN_LEVELS)
   ) exec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (seq_fire),
      .opcode      (mbox_opcode),
      .subsys      (subsys_sel),
      .params      (param_words),
      .status_code (exec_status),
      .res_we      (exec_we),
      .res_val     (exec_val)
   );

endmodule

// File: rtl/hmr_mailbox_responder_chk.sv
module hmr_mailbox_responder_chk
   import hmr_pkg::*;
#(
   parameter int LATENCY = 4,
   parameter int ADDR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic              cmd_done,
   input logic [7:0]        mbox_status,
   input logic              busy
);

   localparam int SW = $clog2(LATENCY + 3) + 1;

   logic          kick;
   logic [SW-1:0] since_q;

   assign kick = host_we && (host_addr == '0);

   // edges elapsed since the last mailbox write, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_q <= '0;
      else if (kick)
         since_q <= SW'(1);
      else if (since_q != '0 && since_q < SW'(LATENCY + 2))
         since_q <= since_q + 1'b1;
   end

   p_clear_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (mbox_status == ST_PENDING) && !cmd_done);

   p_pending_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mbox_status == ST_PENDING) && !cmd_done);

   p_post_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_done) |-> (since_q == SW'(LATENCY + 1)));

   p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && !kick) |=> cmd_done);

   p_done_has_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (mbox_status != ST_PENDING));

   p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_status == ST_PENDING) || (mbox_status == ST_OK) ||
      (mbox_status == ST_ERR) || (mbox_status == ST_UNSUP));

endmodule

bind hmr_mailbox_responder hmr_mailbox_responder_chk #(
   .LATENCY (LATENCY),
   .ADDR_W  (ADDR_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .cmd_done    (cmd_done),
   .mbox_status (mbox_status),
   .busy        (seq_busy)
);

// File: tb/hmr_mailbox_responder_tb_top.sv
module hmr_mailbox_responder_tb_top;

   localparam int NP  = 8;
   localparam int NCH = 8;
   localparam int GL  = 4;
   localparam int LAT = 4;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_we;
   logic [AW-1:0] host_addr;
   logic [15:0]   host_wdata;
   logic [AW-1:0] host_raddr;
   logic [15:0]   host_rdata;
   logic          cmd_done;

   int checks = 0;
   int errors = 0;

   logic [15:0] pm [NP];
   logic [15:0] store_m [6][NCH];
   logic [15:0] cfg_m [6];
   logic [15:0] run_m [6];

   always #10 clk = ~clk;

   hmr_mailbox_responder #(
      .NUM_PARAMS (NP), .NUM_CHANNELS (NCH), .GAIN_LEVELS (GL),
      .LATENCY (LAT), .MAX_POLL (100), .ADDR_W (AW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_raddr (host_raddr),
      .host_rdata (host_rdata), .cmd_done (cmd_done)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [AW-1:0] a, input logic [15:0] d);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hr(input logic [AW-1:0] a, output logic [15:0] d);
      host_raddr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic setp(input int i, input logic [15:0] v);
      hw(AW'(2 + i), v);
      pm[i] = v;
   endtask

   task automatic check_params(input string req);
      logic [15:0] d;
      for (int i = 0; i < NP; i++) begin
         hr(AW'(2 + i), d);
         check(req, d, pm[i]);
      end
   endtask

   // issue a command and follow its completion timing
   task automatic issue(input logic [7:0] op, input logic [7:0] hi, input logic [7:0] exp_st);
      logic [15:0] d;
      hw('0, {hi, op});
      hr('0, d);
      check("R2 status cleared on write", d, {8'h00, op});
      check("R2 done cleared on write", {15'b0, cmd_done}, 16'h0);
      for (int i = 1; i < LAT; i++) begin
         @(negedge clk);
         hr('0, d);
         check("R3 status pending before latency", d, {8'h00, op});
         check("R3 done low before latency", {15'b0, cmd_done}, 16'h0);
      end
      @(negedge clk);
      hr('0, d);
      check("R3 R4 completion code", d, {exp_st, op});
      check("R3 done raised", {15'b0, cmd_done}, 16'h1);
      @(negedge clk);
      check("R3 done held", {15'b0, cmd_done}, 16'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [15:0] v;
      host_we = 1'b0; host_addr = '0; host_wdata = '0; host_raddr = '0;
      rst_n = 1'b0;
      for (int i = 0; i < NP; i++) pm[i] = '0;
      for (int s = 0; s < 6; s++) begin
         cfg_m[s] = '0; run_m[s] = '0;
         for (int c = 0; c < NCH; c++) store_m[s][c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of every word
      for (int a = 0; a < 16; a++) begin
         hr(AW'(a), d);
         check("R1 reset word", d, 16'h0);
      end
      check("R1 reset done", {15'b0, cmd_done}, 16'h0);

      // R11: map and unmapped addresses
      hw(AW'(15), 16'hBEEF);
      hw(AW'(11), 16'h1234);
      hr(AW'(15), d); check("R11 unmapped read", d, 16'h0);
      hr(AW'(11), d); check("R11 unmapped read", d, 16'h0);
      check_params("R11 params untouched by unmapped write");
      hw(AW'(1), 16'h0003);
      hr(AW'(1), d); check("R11 subsystem word", d, 16'h0003);
      setp(5, 16'hA5A5);
      hr(AW'(7), d); check("R11 parameter 5 at address 7", d, 16'hA5A5);

      // R5: single writes to every writable file and channel
      for (int s = 1; s < 6; s++) begin
         if (s == 2) continue;
         for (int c = 0; c < NCH; c++) begin
            v = 16'(16'h1000 * s + 16'h0137 * c + 16'h0005);
            setp(0, 16'(c)); setp(1, 16'h0); setp(2, v);
            hw(AW'(1), 16'(s));
            issue(8'd6, 8'h00, 8'h55);
            store_m[s][c] = v;
            check_params("R5 params unchanged by write");
         end
      end

      // R6: single reads from every subsystem, gains swept on analog in
      for (int s = 0; s < 6; s++) begin
         for (int c = 0; c < NCH; c++) begin
            for (int g = 0; g < ((s == 0) ? GL : 1); g++) begin
               setp(0, 16'(c)); setp(1, 16'(g)); setp(2, 16'hDEAD);
               hw(AW'(1), 16'(s));
               issue(8'd5, 8'h00, 8'h55);
               if (s == 0)      pm[2] = store_m[1][c] >> g;
               else if (s == 2) pm[2] = store_m[3][c];
               else             pm[2] = store_m[s][c];
               hr(AW'(4), d);
               check("R6 single read result", d, pm[2]);
            end
         end
      end

      // R7 R8: configure, start, stop, read back
      for (int s = 0; s < 6; s++) begin
         hw(AW'(1), 16'(s));
         setp(0, 16'(16'hC000 | s));
         issue(8'd1, 8'h00, 8'h55);
         cfg_m[s] = 16'(16'hC000 | s);
         setp(0, 16'h0); setp(1, 16'hFFFF);
         issue(8'd2, 8'h00, 8'h55);
         pm[0] = cfg_m[s]; pm[1] = 16'h0;
         check_params("R7 get configuration");
         issue(8'd3, 8'h00, 8'h55);
         issue(8'd2, 8'h00, 8'h55);
         pm[1] = 16'h1;
         check_params("R8 run flag after start");
         issue(8'd4, 8'h00, 8'h55);
         issue(8'd2, 8'h00, 8'h55);
         pm[1] = 16'h0;
         check_params("R8 run flag after stop");
      end

      // R9: error cases
      setp(0, 16'h0002); setp(1, 16'h0001); setp(2, 16'h7777);
      for (int s = 6; s < 8; s++) begin
         hw(AW'(1), 16'(s));
         for (int op = 1; op <= 6; op++) begin
            issue(8'(op), 8'h00, 8'hAA);
            check_params("R9 bad subsystem leaves params");
         end
      end
      hw(AW'(1), 16'h0001);
      setp(0, 16'(NCH));
      issue(8'd6, 8'h00, 8'hAA);
      issue(8'd5, 8'h00, 8'hAA);
      check_params("R9 bad channel leaves params");
      hw(AW'(1), 16'h0000);
      setp(0, 16'h0003); setp(1, 16'(GL));
      issue(8'd5, 8'h00, 8'hAA);
      check_params("R9 bad gain leaves params");
      setp(1, 16'h0000); setp(2, 16'h4321);
      issue(8'd6, 8'h00, 8'hAA);
      issue(8'd5, 8'h00, 8'h55);
      pm[2] = store_m[1][3];
      check_params("R9 write to analog in ignored");
      hw(AW'(1), 16'h0002);
      setp(2, 16'h4321);
      issue(8'd6, 8'h00, 8'hAA);
      issue(8'd5, 8'h00, 8'h55);
      pm[2] = store_m[3][3];
      check_params("R9 write to digital in ignored");

      // R10 and R2: unsupported opcodes, upper byte of the write ignored
      hw(AW'(1), 16'h0001);
      setp(0, 16'h0001); setp(2, 16'h5A5A);
      for (int op = 0; op < 256; op++) begin
         if (op >= 1 && op <= 6) continue;
         issue(8'(op), 8'(op ^ 8'hA5), 8'hFF);
         check_params("R10 unsupported leaves params");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule